// File: doc/BRIEF.md
# Host Request Target Decoder

This block sits on the processor side of a memory controller hub. Each processor request arrives as an address, a direction (read or write) and a space (memory or I/O). The block chooses one destination for it: local DRAM, the external graphics port, the integrated graphics engine, or the default downstream hub. It can also claim the request itself and finish it locally. The choice is registered and appears one cycle after the request strobe as a one-hot select.

Configuration inputs set the decode:
- **Top of DRAM**, in 64 MB units.
- **Legacy segments**: a 2-bit attribute for each 16 KB segment between 0xC0000 and 0xFFFFF.
- **Display window steering**: a bit that chooses the destination of the 0xA0000–0xBFFFF window.
- **Graphics aperture**: enable, base and limit, in 64 MB units.

Memory requests above the 32-bit space never leave the block. A read of that kind completes with zero data.

When windows overlap, a fixed priority settles the target. Highest first, the order is: local termination, the display window, legacy segments, the aperture, DRAM below the top, and the hub.

Top module: `host_route_dec`

## Requirements
- R1: The response appears exactly one cycle after `req_valid`. While `rsp_valid` is high, `rsp_target` has exactly one bit set, with bit0 = DRAM, bit1 = graphics port, bit2 = integrated graphics, bit3 = hub and bit4 = local terminate. While `rsp_valid` is low, `rsp_target` is zero.
- R2: A memory request with any of address bits 35:32 set selects local terminate. Such a request never selects the hub or the graphics port.
- R3: A locally terminated read raises `rsp_done` in the response cycle, and `host_rdata` is zero in that cycle. A locally terminated write does not raise `rsp_done`.
- R4: Every I/O request selects the hub, including addresses 0x10000 to 0x10002.
- R5: A memory address from 0xA0000 to 0xBFFFF selects integrated graphics when `cfg_vga_igfx` is 1 and the graphics port when it is 0, whatever the top of DRAM.
- R6: A memory address from 0xC0000 to 0xFFFFF uses segment index addr[17:14]. The segment's attribute is `cfg_seg_attr[2i+1:2i]`, encoded as 00 = disabled, 01 = read-only, 10 = write-only, 11 = read/write. A permitted direction selects DRAM. A forbidden direction, or a disabled segment, selects the hub.
- R7: When `cfg_aper_en` is 1, a memory address whose bits 31:26 lie in [`cfg_aper_base`, `cfg_aper_limit`] selects the graphics port, even when it is below the top of DRAM.
- R8: Any other memory address below `cfg_tom`×64 MB selects DRAM. At or above that value it selects the hub.
- R9: Outside a terminated-read response, `host_rdata` equals `fwd_rdata`.
- R10: While reset is held, `rsp_valid`, `rsp_target` and `rsp_done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 36 | Host address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| cfg_tom | input | 7 | Top of DRAM in 64 MB units (64 = 4 GB) |
| cfg_seg_attr | input | 32 | Two attribute bits per legacy segment |
| cfg_vga_igfx | input | 1 | Display window to integrated graphics when 1 |
| cfg_aper_en | input | 1 | Aperture enable |
| cfg_aper_base | input | 6 | Aperture base, 64 MB units |
| cfg_aper_limit | input | 6 | Aperture last block, 64 MB units |
| fwd_rdata | input | 64 | Read data returned by the chosen target |
| rsp_valid | output | 1 | Decision valid |
| rsp_target | output | 5 | One-hot destination |
| rsp_done | output | 1 | Local completion of a terminated read |
| host_rdata | output | 64 | Read data toward the processor |

## Verification
The hardest situation to reach is two windows claiming the same address. Software is expected to avoid it, so ordinary traffic never shows which window wins. The directed tests build these overlaps on purpose. In one, the top of DRAM is raised to the full 4 GB so that the aperture sits inside DRAM. In another, the display-window bit is flipped while the display range is still below the top of DRAM. The same aperture address is then replayed with the aperture disabled, which shows that DRAM takes over once the higher-priority window is gone.

// File: rtl/host_route_pkg.sv
package host_route_pkg;
  localparam int NTGT = 5;

  typedef enum logic [2:0] {
    TGT_DRAM  = 3'd0,
    TGT_GPORT = 3'd1,
    TGT_IGFX  = 3'd2,
    TGT_HUB   = 3'd3,
    TGT_TERM  = 3'd4
  } tgt_e;

  // attribute bit positions: bit0 permits reads, bit1 permits writes
  localparam int ATTR_RD = 0;
  localparam int ATTR_WR = 1;
endpackage

// File: rtl/legacy_seg_decode.sv
module legacy_seg_decode #(
  parameter int NSEG     = 16,
  parameter int SEG_BITS = 14
) (
  input  logic [31:0]       addr,
  input  logic              write,
  input  logic [2*NSEG-1:0] seg_attr,
  output logic              hit,
  output logic              allow
);
  import host_route_pkg::*;

  localparam logic [31:0] TOP_1M  = 32'h0010_0000;
  localparam logic [31:0] SPAN    = 32'(NSEG) << SEG_BITS;
  localparam logic [31:0] BASE    = TOP_1M - SPAN;
  localparam int          IDX_W   = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [NSEG-1:0] perm;
  logic [31:0]     offs;
  logic [IDX_W-1:0] idx;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      assign perm[g] = write ? seg_attr[2*g+ATTR_WR] : seg_attr[2*g+ATTR_RD];
    end
  endgenerate

  always_comb begin
    hit   = (addr >= BASE) && (addr < TOP_1M);
    offs  = addr - BASE;
    idx   = offs[SEG_BITS +: IDX_W];
    allow = perm[idx];
  end
endmodule

// File: rtl/range_match.sv
module range_match #(
  parameter int TOM_W = 7
) (
  input  logic [31:17]     vga_tag,
  input  logic [31:26]     blk,
  input  logic [TOM_W-1:0] tom,
  input  logic             aper_en,
  input  logic [5:0]       aper_base,
  input  logic [5:0]       aper_limit,
  output logic             vga_hit,
  output logic             aper_hit,
  output logic             below_tom
);
  localparam logic [14:0] VGA_TAG = 15'h0005;

  always_comb begin
    vga_hit   = (vga_tag == VGA_TAG);
    aper_hit  = aper_en && (blk >= aper_base) && (blk <= aper_limit);
    below_tom = (TOM_W'(blk) < tom);
  end
endmodule

// File: rtl/route_select.sv
module route_select (
  input  logic                  is_io,
  input  logic                  above_4g,
  input  logic                  vga_hit,
  input  logic                  vga_igfx,
  input  logic                  seg_hit,
  input  logic                  seg_allow,
  input  logic                  aper_hit,
  input  logic                  below_tom,
  output host_route_pkg::tgt_e  tgt
);
  import host_route_pkg::*;

  always_comb begin
    if (is_io)          tgt = TGT_HUB;
    else if (above_4g)  tgt = TGT_TERM;
    else if (vga_hit)   tgt = vga_igfx ? TGT_IGFX : TGT_GPORT;
    else if (seg_hit)   tgt = seg_allow ? TGT_DRAM : TGT_HUB;
    else if (aper_hit)  tgt = TGT_GPORT;
    else if (below_tom) tgt = TGT_DRAM;
    else                tgt = TGT_HUB;
  end
endmodule

// File: rtl/host_route_dec.sv
module host_route_dec #(
  parameter int ADDR_W   = 36,
  parameter int DATA_W   = 64,
  parameter int TOM_W    = 7,
  parameter int NSEG     = 16,
  parameter int SEG_BITS = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic                  req_io,
  input  logic [TOM_W-1:0]      cfg_tom,
  input  logic [2*NSEG-1:0]     cfg_seg_attr,
  input  logic                  cfg_vga_igfx,
  input  logic                  cfg_aper_en,
  input  logic [5:0]            cfg_aper_base,
  input  logic [5:0]            cfg_aper_limit,
  input  logic [DATA_W-1:0]     fwd_rdata,
  output logic                  rsp_valid,
  output logic [host_route_pkg::NTGT-1:0] rsp_target,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     host_rdata
);
  import host_route_pkg::*;

  logic above_4g, vga_hit, seg_hit, seg_allow, aper_hit, below_tom;
  tgt_e tgt_d, tgt_q;
  logic valid_d, valid_q, wr_d, wr_q, term_rd;

  assign above_4g = |req_addr[ADDR_W-1:32];

  legacy_seg_decode #(.NSEG(NSEG), .SEG_BITS(SEG_BITS)) u_seg (
    .addr     (req_addr[31:0]),
    .write    (req_write),
    .seg_attr (cfg_seg_attr),
    .hit      (seg_hit),
    .allow    (seg_allow)
  );

  range_match #(.TOM_W(TOM_W)) u_rng (
    .vga_tag    (req_addr[31:17]),
    .blk        (req_addr[31:26]),
    .tom        (cfg_tom),
    .aper_en    (cfg_aper_en),
    .aper_base  (cfg_aper_base),
    .aper_limit (cfg_aper_limit),
    .vga_hit    (vga_hit),
    .aper_hit   (aper_hit),
    .below_tom  (below_tom)
  );

  route_select u_sel (
    .is_io     (req_io),
    .above_4g  (above_4g),
    .vga_hit   (vga_hit),
    .vga_igfx  (cfg_vga_igfx),
    .seg_hit   (seg_hit),
    .seg_allow (seg_allow),
    .aper_hit  (aper_hit),
    .below_tom (below_tom),
    .tgt       (tgt_d)
  );

  // next-state
  always_comb begin
    valid_d = req_valid;
    wr_d    = req_write;
  end

  // registers with the request strobe as clock enable for the payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tgt_q   <= TGT_HUB;
      wr_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (req_valid) begin
        tgt_q <= tgt_d;
        wr_q  <= wr_d;
      end
    end
  end

  always_comb begin
    term_rd    = valid_q && (tgt_q == TGT_TERM) && !wr_q;
    rsp_valid  = valid_q;
    rsp_target = valid_q ? (NTGT'(1) << tgt_q) : '0;
    rsp_done   = term_rd;
    host_rdata = term_rd ? '0 : fwd_rdata;
  end
endmodule

// File: rtl/host_route_dec_chk.sv
module host_route_dec_chk #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_io,
  input logic              rsp_valid,
  input logic [4:0]        rsp_target,
  input logic              rsp_done,
  input logic [DATA_W-1:0] host_rdata
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_target) == 1));
  assert_high_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && (|req_addr[ADDR_W-1:32])) |=> (rsp_target == 5'b10000));
  assert_done_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_target[4] && (host_rdata == '0)));
  assert_no_done_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_done);
  assert_io_hub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io) |=> (rsp_target == 5'b01000));
endmodule

bind host_route_dec host_route_dec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/host_route_dec_tb_top.sv
module host_route_dec_tb_top;
  logic        clk, rst_n, req_valid, req_write, req_io;
  logic [35:0] req_addr;
  logic [6:0]  cfg_tom;
  logic [31:0] cfg_seg_attr;
  logic        cfg_vga_igfx, cfg_aper_en;
  logic [5:0]  cfg_aper_base, cfg_aper_limit;
  logic [63:0] fwd_rdata, host_rdata;
  logic        rsp_valid, rsp_done;
  logic [4:0]  rsp_target;
  int n_run = 0, n_fail = 0;

  localparam logic [4:0] DR = 5'b00001, GP = 5'b00010, IG = 5'b00100,
                         HB = 5'b01000, TM = 5'b10000;
  localparam int NV = 19;
  // {addr, write, io, expected target}
  localparam logic [42:0] VEC [NV] = '{
    {36'h0_0000_1000, 1'b0, 1'b0, DR},  // R8
    {36'h0_1FFF_FFFF, 1'b0, 1'b0, DR},  // R8
    {36'h0_2000_0000, 1'b0, 1'b0, HB},  // R8
    {36'h1_0000_0000, 1'b0, 1'b0, TM},  // R2
    {36'hF_FFFF_FFF0, 1'b1, 1'b0, TM},  // R2
    {36'h0_000A_0000, 1'b0, 1'b0, GP},  // R5
    {36'h0_000B_FFFF, 1'b1, 1'b0, GP},  // R5
    {36'h0_000C_0000, 1'b0, 1'b0, HB},  // R6
    {36'h0_000C_4000, 1'b0, 1'b0, DR},  // R6
    {36'h0_000C_4000, 1'b1, 1'b0, HB},  // R6
    {36'h0_000C_8000, 1'b0, 1'b0, HB},  // R6
    {36'h0_000C_8000, 1'b1, 1'b0, DR},  // R6
    {36'h0_000F_FFFF, 1'b1, 1'b0, DR},  // R6
    {36'h0_4000_0000, 1'b0, 1'b0, GP},  // R7
    {36'h0_47FF_FFFF, 1'b1, 1'b0, GP},  // R7
    {36'h0_4800_0000, 1'b0, 1'b0, HB},  // R7
    {36'h0_0001_0002, 1'b0, 1'b1, HB},  // R4
    {36'h0_0000_0CF8, 1'b1, 1'b1, HB},  // R4
    {36'h0_0009_FFFF, 1'b0, 1'b0, DR}   // R8
  };

  host_route_dec dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [35:0] a, input logic w, input logic io);
    @(negedge clk);
    req_addr = a; req_write = w; req_io = io; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_io = 1'b0;
    cfg_tom = 7'd8; cfg_seg_attr = 32'hE4E4_E4E4; cfg_vga_igfx = 1'b0;
    cfg_aper_en = 1'b1; cfg_aper_base = 6'd16; cfg_aper_limit = 6'd17;
    fwd_rdata = 64'hDEAD_BEEF_0123_4567;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", 64'(rsp_valid), 64'd0);
    check("R10 target in reset", 64'(rsp_target), 64'd0);
    check("R10 done in reset", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][42:7], VEC[i][6], VEC[i][5]);
      check("R1 valid", 64'(rsp_valid), 64'd1);
      check($sformatf("R1/vector %0d target", i), 64'(rsp_target), 64'(VEC[i][4:0]));
    end

    @(negedge clk);
    check("R1 idle valid", 64'(rsp_valid), 64'd0);
    check("R1 idle target", 64'(rsp_target), 64'd0);

    issue(36'h2_0000_0040, 1'b0, 1'b0);
    check("R3 done on terminated read", 64'(rsp_done), 64'd1);
    check("R3 zero data", host_rdata, 64'd0);
    issue(36'h2_0000_0040, 1'b1, 1'b0);
    check("R3 no done on terminated write", 64'(rsp_done), 64'd0);
    issue(36'h0_0000_2000, 1'b0, 1'b0);
    check("R9 passthrough data", host_rdata, 64'hDEAD_BEEF_0123_4567);
    check("R9 no done", 64'(rsp_done), 64'd0);

    cfg_vga_igfx = 1'b1;
    issue(36'h0_000A_8000, 1'b0, 1'b0);
    check("R5 display window to integrated graphics", 64'(rsp_target), 64'(IG));

    cfg_tom = 7'd64;
    issue(36'h0_4400_0000, 1'b0, 1'b0);
    check("R7 aperture over DRAM", 64'(rsp_target), 64'(GP));
    issue(36'h0_FFFF_FFFF, 1'b0, 1'b0);
    check("R8 full 4GB DRAM", 64'(rsp_target), 64'(DR));
    cfg_aper_en = 1'b0;
    issue(36'h0_4400_0000, 1'b0, 1'b0);
    check("R7 aperture disabled falls to DRAM", 64'(rsp_target), 64'(DR));

    cfg_seg_attr = 32'h0000_0000;
    issue(36'h0_000F_C000, 1'b1, 1'b0);
    check("R6 disabled segment write to hub", 64'(rsp_target), 64'(HB));
    issue(36'h0_0001_0000, 1'b1, 1'b1);
    check("R4 I/O at 0x10000", 64'(rsp_target), 64'(HB));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule